// File: doc/BRIEF.md
# DMA Line-Splitting Sequencer

This block takes a single DMA transfer from a requester (byte address, byte length, direction, and whether a response is wanted) and turns it into a series of transactions, each no larger than one cache line, for a downstream coherence or memory port. Only the first transaction may start in the middle of a line; it ends at the line boundary. Every later transaction begins on a line boundary. Each transaction is sent only after the previous one has been acknowledged (for stores) or has returned its data (for loads).

The requester's payload stays outside the block. For stores, the block reads payload bytes through a buffer port, indexed by how many bytes have already completed, and places them at the correct byte lanes of a line-wide data bus with matching byte enables. For loads, it writes the returned bytes, aligned back to lane 0, into the requester's buffer at the completed-byte position. A second request that arrives while a transfer is in flight is refused. The refused requester gets a one-cycle retry pulse once the transfer finishes. A drain request is answered as soon as no transfer is outstanding.

Top module: `dma_line_splitter`

## Requirements
- R1: At most one transfer is in flight. A request seen while busy raises `req_busy`, is not accepted, and produces no downstream transaction.
- R2: The first transaction starts at the request address. Its length is the request length when the request fits inside that line, and otherwise the line size minus the in-line offset.
- R3: Each later transaction starts at request address plus completed bytes, which is a line boundary. Its length is the smaller of the remaining bytes and the line size. The next transaction is not sent until the current one is answered by `dn_done`.
- R4: Store transactions have `dn_store`=1. Payload byte `buf_raddr+k` appears in line lane `off+k`, where lane j is `dn_data[8j+7:8j]` and `off` is the address's in-line offset. `dn_be` bit j is set exactly for the lanes written, so bytes outside the range stay unchanged.
- R5: Load transactions have `dn_store`=0. On `dn_done`, lane `off+k` of `dn_rdata` is delivered as byte k of `buf_wdata`, with `buf_waddr` equal to the completed-byte count and `buf_wlen` equal to that transaction's length.
- R6: The busy state is left in the same cycle as the final `dn_done`. A new request presented in the following cycle, which is the response cycle, is accepted.
- R7: A refused request causes exactly one `retry_pulse` cycle, in the cycle after the final `dn_done`. This includes a refusal that coincides with the final `dn_done`.
- R8: `resp_valid` pulses for one cycle, one cycle after the final `dn_done`, only when the request asked for a response.
- R9: `drain_req` while idle gives `drain_done` in the next cycle. `drain_req` while busy gives `drain_done` in the cycle after the final `dn_done`, and not before.
- R10: A request with length 0, or whose byte range falls outside [MEM_BASE, MEM_BASE+MEM_SIZE), raises `req_error` and issues nothing. A range ending exactly at the limit is accepted.
- R11: `dn_valid` and the transaction fields stay stable until `dn_ready`. A transaction is counted once, whatever the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request presented |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| req_write | input | 1 | 1 = store transfer, 0 = load transfer |
| req_need_resp | input | 1 | Requester wants a completion response |
| req_accept | output | 1 | Request taken this cycle |
| req_busy | output | 1 | Request refused because a transfer is in flight |
| req_error | output | 1 | Request rejected as zero-length or out of range |
| retry_pulse | output | 1 | One-cycle hint to re-present a refused request |
| resp_valid | output | 1 | Completion response |
| dn_valid | output | 1 | Downstream transaction valid |
| dn_ready | input | 1 | Downstream takes the transaction |
| dn_addr | output | ADDR_W | Transaction byte address |
| dn_len | output | LEN_W | Transaction byte count |
| dn_store | output | 1 | 1 = store, 0 = load |
| dn_be | output | LINE_BYTES | Per-lane byte enables |
| dn_data | output | 8*LINE_BYTES | Store data in line lanes |
| dn_done | input | 1 | Acknowledge or data return for the current transaction |
| dn_rdata | input | 8*LINE_BYTES | Returned line data |
| buf_raddr | output | LEN_W | Payload offset read for stores |
| buf_rdata | input | 8*LINE_BYTES | Payload bytes starting at buf_raddr |
| buf_we | output | 1 | Load data write strobe |
| buf_waddr | output | LEN_W | Buffer offset for load data |
| buf_wlen | output | LEN_W | Valid bytes in buf_wdata |
| buf_wdata | output | 8*LINE_BYTES | Load data aligned to lane 0 |
| drain_req | input | 1 | Drain request pulse |
| drain_done | output | 1 | Drain complete pulse |
| idle | output | 1 | No transfer in flight |

## Verification
Two events can land in the same cycle: a new request being refused, and the final acknowledgement that ends the transfer. The bench presents a request exactly in the cycle its responder raises the last `dn_done`. It then expects that request to be refused, `retry_pulse` and `resp_valid` to appear together one cycle later, and a fresh request offered in that response cycle to be accepted at once. The same completion cycle is also used as the point where a drain that was pending during the transfer must report done.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

   typedef enum logic [1:0] {
      SP_IDLE  = 2'd0,
      SP_ISSUE = 2'd1,
      SP_WAIT  = 2'd2
   } sp_state_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
   parameter int LEN_W      = 12,
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES)
) (
   input  logic [OFF_W-1:0]      line_off,
   input  logic [LEN_W-1:0]      remain,
   output logic [LEN_W-1:0]      chunk_len,
   output logic [LINE_BYTES-1:0] chunk_be
);

   logic [LEN_W:0] room;
   logic [LEN_W:0] end_pos;

   // bytes left in the current line from the offset onward
   assign room      = (LEN_W+1)'(LINE_BYTES) - (LEN_W+1)'(line_off);
   assign chunk_len = ({1'b0, remain} < room) ? remain : room[LEN_W-1:0];
   assign end_pos   = (LEN_W+1)'(line_off) + {1'b0, chunk_len};

   for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
      assign chunk_be[i] = ((LEN_W+1)'(i) >= (LEN_W+1)'(line_off)) &&
                           ((LEN_W+1)'(i) <  end_pos);
   end

endmodule

// File: rtl/dma_lane_shift.sv
module dma_lane_shift #(
   parameter int LINE_BYTES = 64,
   parameter bit SHIFT_UP   = 1'b1,
   localparam int OFF_W     = $clog2(LINE_BYTES)
) (
   input  logic [8*LINE_BYTES-1:0] din,
   input  logic [OFF_W-1:0]        lane_off,
   output logic [8*LINE_BYTES-1:0] dout
);

   if (SHIFT_UP) begin : g_up
      // payload lane 0 moves to line lane lane_off
      assign dout = din << {lane_off, 3'b000};
   end else begin : g_down
      // line lane lane_off moves to payload lane 0
      assign dout = din >> {lane_off, 3'b000};
   end

endmodule

// File: rtl/dma_split_ctrl.sv
module dma_split_ctrl
   import dma_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_write,
   input  logic              req_need_resp,
   input  logic              req_bad,
   input  logic              dn_ready,
   input  logic              dn_done,
   input  logic [LEN_W-1:0]  chunk_len,
   input  logic              drain_req,
   output logic              req_accept,
   output logic              req_busy,
   output logic              req_error,
   output sp_state_e         state,
   output logic [ADDR_W-1:0] base_addr,
   output logic [LEN_W-1:0]  total_len,
   output logic [LEN_W-1:0]  bytes_issued,
   output logic [LEN_W-1:0]  bytes_done,
   output logic              xfer_write,
   output logic              resp_valid,
   output logic              retry_pulse,
   output logic              drain_done
);

   sp_state_e state_nxt;
   logic      want_resp;
   logic      retry_pend;
   logic      draining;
   logic      last_chunk;
   logic      finish;
   logic      busy_nxt;

   assign req_accept = req_valid && (state == SP_IDLE) && !req_bad;
   assign req_error  = req_valid && (state == SP_IDLE) &&  req_bad;
   assign req_busy   = req_valid && (state != SP_IDLE);

   assign last_chunk = (bytes_issued == total_len);
   assign finish     = (state == SP_WAIT) && dn_done && last_chunk;

   always_comb begin
      state_nxt = state;
      unique case (state)
         SP_IDLE:  if (req_accept) state_nxt = SP_ISSUE;
         SP_ISSUE: if (dn_ready)   state_nxt = SP_WAIT;
         SP_WAIT:  if (dn_done)    state_nxt = last_chunk ? SP_IDLE : SP_ISSUE;
         default:                  state_nxt = SP_IDLE;
      endcase
   end

   assign busy_nxt = (state_nxt != SP_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= SP_IDLE;
         base_addr    <= '0;
         total_len    <= '0;
         bytes_issued <= '0;
         bytes_done   <= '0;
         xfer_write   <= 1'b0;
         want_resp    <= 1'b0;
      end else begin
         state <= state_nxt;
         unique case (state)
            SP_IDLE: if (req_accept) begin
               base_addr    <= req_addr;
               total_len    <= req_len;
               bytes_issued <= '0;
               bytes_done   <= '0;
               xfer_write   <= req_write;
               want_resp    <= req_need_resp;
            end
            SP_ISSUE: if (dn_ready) bytes_issued <= bytes_issued + chunk_len;
            SP_WAIT:  if (dn_done)  bytes_done   <= bytes_issued;
            default: ;
         endcase
      end
   end

   // completion side effects, all one cycle after the final answer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         retry_pend  <= 1'b0;
         retry_pulse <= 1'b0;
         resp_valid  <= 1'b0;
         draining    <= 1'b0;
         drain_done  <= 1'b0;
      end else begin
         retry_pend  <= finish ? 1'b0 : (retry_pend || req_busy);
         retry_pulse <= finish && (retry_pend || req_busy);
         resp_valid  <= finish && want_resp;
         draining    <= (draining || drain_req) &&  busy_nxt;
         drain_done  <= (draining || drain_req) && !busy_nxt;
      end
   end

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
   import dma_split_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              LEN_W      = 12,
   parameter int              LINE_BYTES = 64,
   parameter longint unsigned MEM_BASE   = 64'h0,
   parameter longint unsigned MEM_SIZE   = 64'h1_0000_0000,
   localparam int             OFF_W      = $clog2(LINE_BYTES),
   localparam int             DATA_W     = 8 * LINE_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_write,
   input  logic              req_need_resp,
   output logic              req_accept,
   output logic              req_busy,
   output logic              req_error,
   output logic              retry_pulse,
   output logic              resp_valid,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [LEN_W-1:0]  dn_len,
   output logic              dn_store,
   output logic [LINE_BYTES-1:0] dn_be,
   output logic [DATA_W-1:0] dn_data,
   input  logic              dn_done,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic [LEN_W-1:0]  buf_raddr,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic              buf_we,
   output logic [LEN_W-1:0]  buf_waddr,
   output logic [LEN_W-1:0]  buf_wlen,
   output logic [DATA_W-1:0] buf_wdata,
   input  logic              drain_req,
   output logic              drain_done,
   output logic              idle
);

   localparam logic [ADDR_W:0] MEM_LO = (ADDR_W+1)'(MEM_BASE);
   localparam logic [ADDR_W:0] MEM_HI = (ADDR_W+1)'(MEM_BASE + MEM_SIZE);

   if ((1 << OFF_W) != LINE_BYTES || LINE_BYTES < 2) begin : g_bad_line
      initial $fatal(1, "LINE_BYTES must be a power of two of at least 2");
   end
   if (LEN_W <= OFF_W) begin : g_bad_len
      initial $fatal(1, "LEN_W must exceed the line offset width");
   end
   if (ADDR_W < LEN_W) begin : g_bad_addr
      initial $fatal(1, "ADDR_W must be at least LEN_W");
   end

   sp_state_e         state;
   logic [ADDR_W-1:0] base_addr;
   logic [LEN_W-1:0]  total_len;
   logic [LEN_W-1:0]  bytes_issued;
   logic [LEN_W-1:0]  bytes_done;
   logic              xfer_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [OFF_W-1:0]  cur_off;
   logic [LEN_W-1:0]  chunk_len;
   logic [LINE_BYTES-1:0] chunk_be;
   logic [DATA_W-1:0] wr_lanes;
   logic [ADDR_W:0]   req_end;
   logic              req_bad;

   // range and length screening of an incoming request
   assign req_end = {1'b0, req_addr} + (ADDR_W+1)'(req_len);
   assign req_bad = (req_len == '0) || ({1'b0, req_addr} < MEM_LO) || (req_end > MEM_HI);

   dma_split_ctrl #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_addr      (req_addr),
      .req_len       (req_len),
      .req_write     (req_write),
      .req_need_resp (req_need_resp),
      .req_bad       (req_bad),
      .dn_ready      (dn_ready),
      .dn_done       (dn_done),
      .chunk_len     (chunk_len),
      .drain_req     (drain_req),
      .req_accept    (req_accept),
      .req_busy      (req_busy),
      .req_error     (req_error),
      .state         (state),
      .base_addr     (base_addr),
      .total_len     (total_len),
      .bytes_issued  (bytes_issued),
      .bytes_done    (bytes_done),
      .xfer_write    (xfer_write),
      .resp_valid    (resp_valid),
      .retry_pulse   (retry_pulse),
      .drain_done    (drain_done)
   );

   // current transaction address; in-line offset is non-zero only for the first
   assign cur_addr = base_addr + ADDR_W'(bytes_done);
   assign cur_off  = cur_addr[OFF_W-1:0];

   dma_chunk_calc #(
      .LEN_W      (LEN_W),
      .LINE_BYTES (LINE_BYTES)
   ) u_chunk (
      .line_off  (cur_off),
      .remain    (total_len - bytes_done),
      .chunk_len (chunk_len),
      .chunk_be  (chunk_be)
   );

   dma_lane_shift #(
      .LINE_BYTES (LINE_BYTES),
      .SHIFT_UP   (1'b1)
   ) u_wr_shift (
      .din      (buf_rdata),
      .lane_off (cur_off),
      .dout     (wr_lanes)
   );

   dma_lane_shift #(
      .LINE_BYTES (LINE_BYTES),
      .SHIFT_UP   (1'b0)
   ) u_rd_shift (
      .din      (dn_rdata),
      .lane_off (cur_off),
      .dout     (buf_wdata)
   );

   assign dn_valid  = (state == SP_ISSUE);
   assign dn_addr   = cur_addr;
   assign dn_len    = chunk_len;
   assign dn_store  = xfer_write;
   assign dn_be     = chunk_be;
   assign dn_data   = xfer_write ? wr_lanes : '0;
   assign buf_raddr = bytes_done;

   assign buf_we    = (state == SP_WAIT) && dn_done && !xfer_write;
   assign buf_waddr = bytes_done;
   assign buf_wlen  = bytes_issued - bytes_done;

   assign idle      = (state == SP_IDLE);

endmodule

// File: rtl/dma_split_chk.sv
module dma_split_chk #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_accept,
   input logic              req_busy,
   input logic              req_error,
   input logic              retry_pulse,
   input logic              resp_valid,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [ADDR_W-1:0] dn_addr,
   input logic [LEN_W-1:0]  dn_len,
   input logic [LINE_BYTES-1:0] dn_be,
   input logic              drain_done,
   input logic              idle
);

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      req_accept |-> idle) else $error("accept while busy"); // R1

   AST_BUSY_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_busy |-> !req_accept && !idle) else $error("busy refusal mixed"); // R1

   AST_CHUNK_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (dn_len != '0) &&
         (32'(dn_addr[OFF_W-1:0]) + 32'(dn_len) <= 32'(LINE_BYTES)))
      else $error("chunk crosses a line"); // R2

   AST_BE_MATCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> ($countones(dn_be) == 32'(dn_len))) else $error("enables vs length"); // R4

   AST_IDLE_AT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> idle) else $error("response while busy"); // R6

   AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      retry_pulse |=> !retry_pulse) else $error("retry longer than one cycle"); // R7

   AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid) else $error("response longer than one cycle"); // R8

   AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> idle) else $error("drain done while busy"); // R9

   AST_ERR_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      req_error |-> !req_accept && idle) else $error("error request taken"); // R10

   AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_len))
      else $error("transaction changed while stalled"); // R11

endmodule

bind dma_line_splitter dma_split_chk #(
   .ADDR_W     (ADDR_W),
   .LEN_W      (LEN_W),
   .LINE_BYTES (LINE_BYTES)
) u_split_chk (.*);

// File: tb/tb_dma_line_splitter.sv
`timescale 1ns/1ps
module tb_dma_line_splitter;

   localparam int AW = 32;
   localparam int LW = 12;
   localparam int LB = 16;
   localparam int DW = 8 * LB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          req_write = 1'b0;
   logic          req_need_resp = 1'b0;
   logic          req_accept, req_busy, req_error, retry_pulse, resp_valid;
   logic          dn_valid, dn_store;
   logic          dn_ready = 1'b1;
   logic [AW-1:0] dn_addr;
   logic [LW-1:0] dn_len;
   logic [LB-1:0] dn_be;
   logic [DW-1:0] dn_data;
   logic          dn_done = 1'b0;
   logic [DW-1:0] dn_rdata = '0;
   logic [LW-1:0] buf_raddr, buf_waddr, buf_wlen;
   logic [DW-1:0] buf_rdata, buf_wdata;
   logic          buf_we;
   logic          drain_req = 1'b0;
   logic          drain_done, idle;

   always #5 clk = ~clk;

   dma_line_splitter #(
      .ADDR_W (AW), .LEN_W (LW), .LINE_BYTES (LB),
      .MEM_BASE (64'h0), .MEM_SIZE (64'd1024)
   ) dut (.*);

   logic [7:0]  mem [0:1023];
   logic [7:0]  src [0:255];
   logic [7:0]  dst [0:255];
   logic [AW-1:0] log_addr  [0:15];
   logic [LW-1:0] log_len   [0:15];
   logic          log_store [0:15];
   int nlog = 0;
   int lat_cnt = 0;
   int hold_cfg = 0;
   int hold_left = 0;
   logic [AW-1:0] pend_base = '0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always_comb begin
      for (int k = 0; k < LB; k++) buf_rdata[8*k +: 8] = src[(int'(buf_raddr) + k) & 255];
   end

   always @(posedge clk) begin
      if (buf_we)
         for (int k = 0; k < LB; k++)
            if (k < int'(buf_wlen)) dst[(int'(buf_waddr) + k) & 255] <= buf_wdata[8*k +: 8];
   end

   // downstream model: optional stall, then answer two cycles after acceptance
   always @(negedge clk) begin
      dn_done = 1'b0;
      if (lat_cnt > 0) begin
         lat_cnt--;
         if (lat_cnt == 0) begin
            dn_done = 1'b1;
            for (int i = 0; i < LB; i++) dn_rdata[8*i +: 8] = mem[(int'(pend_base) + i) & 1023];
         end
      end
      if (dn_valid && rst_n) begin
         if (hold_left > 0) begin
            dn_ready = 1'b0;
            hold_left--;
         end else begin
            dn_ready = 1'b1;
            if (nlog < 16) begin
               log_addr[nlog]  = dn_addr;
               log_len[nlog]   = dn_len;
               log_store[nlog] = dn_store;
            end
            nlog++;
            pend_base = dn_addr & ~AW'(LB - 1);
            if (dn_store)
               for (int i = 0; i < LB; i++)
                  if (dn_be[i]) mem[(int'(pend_base) + i) & 1023] = dn_data[8*i +: 8];
            lat_cnt   = 2;
            hold_left = hold_cfg;
         end
      end else begin
         dn_ready = 1'b1;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic fill_src(input int seed);
      for (int k = 0; k < 256; k++) src[k] = 8'(k * 3 + seed);
   endtask

   task automatic start_req(input int a, input int l, input bit wr, input bit nr, input string tag);
      step();
      req_valid = 1'b1; req_addr = AW'(a); req_len = LW'(l);
      req_write = wr; req_need_resp = nr;
      #1;
      check(req_accept === 1'b1, tag, longint'(req_accept), 1);
      step();
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && idle !== 1'b1; i++) step();
   endtask

   task automatic check_chunk(input int i, input int a, input int l, input bit st, input string tag);
      check(log_addr[i] == AW'(a), tag, longint'(log_addr[i]), a);
      check(log_len[i] == LW'(l), tag, longint'(log_len[i]), l);
      check(log_store[i] == st, tag, longint'(log_store[i]), st);
   endtask

   task automatic t_reset();
      check(idle === 1'b1 && dn_valid === 1'b0, "R1 reset idle", longint'({idle, dn_valid}), 2);
      check(resp_valid === 1'b0 && retry_pulse === 1'b0 && drain_done === 1'b0,
            "R8 reset quiet", longint'({resp_valid, retry_pulse, drain_done}), 0);
   endtask

   task automatic t_write_split();
      bit ok = 1'b1;
      fill_src(8'hA0);
      nlog = 0;
      start_req(10, 30, 1'b1, 1'b1, "R4 write accept");
      wait_idle();
      check(nlog == 3, "R3 write chunk count", nlog, 3);
      check_chunk(0, 10, 6, 1'b1, "R2 write first chunk");
      check_chunk(1, 16, 16, 1'b1, "R3 write middle chunk");
      check_chunk(2, 32, 8, 1'b1, "R3 write last chunk");
      for (int k = 0; k < 30; k++) if (mem[10 + k] !== src[k]) ok = 1'b0;
      check(ok, "R4 write payload placement", longint'(mem[10]), longint'(src[0]));
      check(mem[9] == 8'(9 ^ 8'h55) && mem[40] == 8'(40 ^ 8'h55), "R4 bytes outside untouched",
            longint'({mem[9], mem[40]}), longint'({8'(9 ^ 8'h55), 8'(40 ^ 8'h55)}));
   endtask

   task automatic t_read_split();
      bit ok = 1'b1;
      nlog = 0;
      hold_cfg = 2; hold_left = 2;
      start_req(19, 40, 1'b0, 1'b1, "R5 read accept");
      wait_idle();
      hold_cfg = 0; hold_left = 0;
      check(nlog == 3, "R11 stalled chunks counted once", nlog, 3);
      check_chunk(0, 19, 13, 1'b0, "R2 read first chunk");
      check_chunk(1, 32, 16, 1'b0, "R3 read middle chunk");
      check_chunk(2, 48, 11, 1'b0, "R3 read last chunk");
      for (int k = 0; k < 40; k++) if (dst[k] !== mem[19 + k]) ok = 1'b0;
      check(ok, "R5 read gather", longint'(dst[39]), longint'(mem[58]));
   endtask

   task automatic t_read_single();
      nlog = 0;
      start_req(33, 5, 1'b0, 1'b1, "R2 short read accept");
      wait_idle();
      check(nlog == 1, "R2 single chunk count", nlog, 1);
      check_chunk(0, 33, 5, 1'b0, "R2 single chunk");
      check(dst[0] === mem[33] && dst[4] === mem[37], "R5 short gather",
            longint'(dst[4]), longint'(mem[37]));
   endtask

   task automatic t_refuse_retry();
      int resp_seen = 0;
      int retry_seen = 0;
      bit early = 1'b0;
      nlog = 0;
      start_req(64, 48, 1'b0, 1'b1, "R1 long read accept");
      step();
      req_valid = 1'b1; req_addr = AW'(200); req_len = LW'(4); req_write = 1'b1;
      #1;
      check(req_busy === 1'b1 && req_accept === 1'b0, "R1 refused while busy",
            longint'({req_busy, req_accept}), 2);
      step();
      req_valid = 1'b0;
      for (int i = 0; i < 200 && resp_seen == 0; i++) begin
         step();
         if (resp_valid === 1'b1) begin
            resp_seen++;
            if (retry_pulse === 1'b1) retry_seen++;
         end else if (retry_pulse === 1'b1) early = 1'b1;
      end
      check(retry_seen == 1 && !early, "R7 retry with completion", retry_seen, 1);
      step();
      check(retry_pulse === 1'b0 && resp_valid === 1'b0, "R8 pulses end",
            longint'({retry_pulse, resp_valid}), 0);
      check(nlog == 3, "R1 refused request issued nothing", nlog, 3);
   endtask

   task automatic t_collision();
      bit ok = 1'b1;
      fill_src(8'h31);
      nlog = 0;
      start_req(80, 4, 1'b0, 1'b1, "R6 short read accept");
      for (int i = 0; i < 50 && dn_done !== 1'b1; i++) step();
      req_valid = 1'b1; req_addr = AW'(96); req_len = LW'(3); req_write = 1'b1; req_need_resp = 1'b0;
      #1;
      check(req_busy === 1'b1, "R7 refused on final answer", longint'(req_busy), 1);
      step();
      #1;
      check(resp_valid === 1'b1, "R8 response one cycle after", longint'(resp_valid), 1);
      check(retry_pulse === 1'b1, "R7 retry for coincident refusal", longint'(retry_pulse), 1);
      check(req_accept === 1'b1, "R6 accept in response cycle", longint'(req_accept), 1);
      step();
      req_valid = 1'b0;
      wait_idle();
      for (int k = 0; k < 3; k++) if (mem[96 + k] !== src[k]) ok = 1'b0;
      check(ok, "R4 retried write landed", longint'(mem[96]), longint'(src[0]));
   endtask

   task automatic t_noresp();
      int resp_seen = 0;
      bit ok = 1'b1;
      fill_src(8'h77);
      step();
      req_valid = 1'b1; req_addr = AW'(112); req_len = LW'(20); req_write = 1'b1; req_need_resp = 1'b0;
      step();
      req_valid = 1'b0;
      for (int i = 0; i < 200 && idle !== 1'b1; i++) begin
         step();
         if (resp_valid === 1'b1) resp_seen++;
      end
      step();
      if (resp_valid === 1'b1) resp_seen++;
      check(resp_seen == 0, "R8 no response when not wanted", resp_seen, 0);
      for (int k = 0; k < 20; k++) if (mem[112 + k] !== src[k]) ok = 1'b0;
      check(ok, "R4 unanswered write landed", longint'(mem[112]), longint'(src[0]));
   endtask

   task automatic t_error();
      nlog = 0;
      step();
      req_valid = 1'b1; req_addr = AW'(40); req_len = '0; req_write = 1'b0; req_need_resp = 1'b1;
      #1;
      check(req_error === 1'b1 && req_accept === 1'b0, "R10 zero length", longint'({req_error, req_accept}), 2);
      step();
      req_addr = AW'(1020); req_len = LW'(8);
      #1;
      check(req_error === 1'b1 && req_accept === 1'b0, "R10 out of range", longint'({req_error, req_accept}), 2);
      step();
      req_valid = 1'b0;
      step(); step();
      check(idle === 1'b1 && nlog == 0, "R10 nothing issued", nlog, 0);
      start_req(1016, 8, 1'b0, 1'b1, "R10 range at limit accepted");
      wait_idle();
   endtask

   task automatic t_drain();
      int early = 0;
      int done_at_resp = 0;
      step();
      drain_req = 1'b1;
      step();
      drain_req = 1'b0;
      check(drain_done === 1'b1, "R9 idle drain next cycle", longint'(drain_done), 1);
      step();
      check(drain_done === 1'b0, "R9 idle drain one pulse", longint'(drain_done), 0);
      start_req(128, 36, 1'b0, 1'b1, "R9 busy read accept");
      drain_req = 1'b1;
      step();
      drain_req = 1'b0;
      for (int i = 0; i < 200 && done_at_resp == 0; i++) begin
         if (resp_valid === 1'b1) done_at_resp = drain_done ? 1 : 2;
         else if (drain_done === 1'b1) early++;
         if (done_at_resp == 0) step();
      end
      check(early == 0, "R9 no drain while busy", early, 0);
      check(done_at_resp == 1, "R9 drain with completion", done_at_resp, 1);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i ^ 8'h55);
      for (int i = 0; i < 256; i++) dst[i] = 8'h00;
      fill_src(0);
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_write_split();
      t_read_split();
      t_read_single();
      t_refuse_retry();
      t_collision();
      t_noresp();
      t_error();
      t_drain();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule